// File: doc/BRIEF.md
# Two-Wire Bus Master Arbitration Guard

This block watches the data line of a multi-master two-wire bus on behalf of one master and decides when that master has lost arbitration. It takes the rising-edge sample strobe and the end-of-bit strobe from the master's clock generator. It also takes the level the master wants on SDA, the level actually sampled on SDA, the position inside the current byte and the current operating mode. From these it produces a latched lost flag, a corrected operating mode, a gated SDA drive level and an enable for the SCL pulse generator.

As a transmitter, the master loses when it releases SDA (logic 1) and the line is sampled low on a data bit. As a receiver, it can only lose during the acknowledge slot, while it is sending a not-acknowledge and another device pulls SDA low. Once it has lost, the block reports slave receiver mode at once and releases SDA. It keeps the SCL generator enabled until the ninth clock of the current byte has ended, then blocks further pulses. Software clears the flag, which restores normal operation.

Top module: `i2c_arb_guard`

## Requirements
- R1: After reset, arb_lost is 0, scl_en is 1, mode_out follows mode_in and sda_out follows sda_drive.
- R2: With mode_in = 2'b00 (master transmitter) and bit_idx from 0 to 7, a cycle with scl_rise_stb high, sda_drive 1 and sda_in 0 sets arb_lost from the next cycle.
- R3: No loss is detected when sda_in equals sda_drive, when sda_drive is 0, or when sda_in differs from sda_drive but scl_rise_stb is low.
- R4: In master transmitter mode, SDA sampled low during the acknowledge slot (bit_idx = 8) is not a loss.
- R5: With mode_in = 2'b01 (master receiver), a loss is detected only at bit_idx = 8 with sda_drive 1 (not-acknowledge) and sda_in 0 on the sample strobe. A low line during bits 0 to 7, or during an acknowledge (sda_drive 0), is not a loss.
- R6: While arb_lost is 1, mode_out is 2'b10 (slave receiver); otherwise it equals mode_in.
- R7: While arb_lost is 1, sda_out is 1 (released) whatever sda_drive is.
- R8: After a loss, scl_en stays 1 until a cycle with bit_done_stb high and bit_idx = 8, and it is 0 from the next cycle on.
- R9: arb_lost and a cleared scl_en stay as they are until clr_lost is high for a cycle, which returns both to their reset values from the next cycle.
- R10: With mode_in = 2'b10 or 2'b11 (slave modes), no loss is ever detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_rise_stb | input | 1 | One-cycle strobe at the SDA sample point while SCL is high |
| bit_done_stb | input | 1 | One-cycle strobe when the current bit's SCL pulse has ended |
| bit_idx | input | 4 | Bit position in the byte: 0 to 7 for data, 8 for acknowledge |
| mode_in | input | 2 | Current mode: 00 master tx, 01 master rx, 10 slave rx, 11 slave tx |
| sda_drive | input | 1 | Level this master wants on SDA (1 = released) |
| sda_in | input | 1 | Sampled SDA line level |
| clr_lost | input | 1 | Software clear of the lost flag |
| arb_lost | output | 1 | Latched arbitration-lost flag, fed to the interrupt logic |
| mode_out | output | 2 | Effective mode after any loss |
| sda_out | output | 1 | SDA level to drive, forced released after a loss |
| scl_en | output | 1 | Enable for the SCL pulse generator |

## Verification
On every cycle, the assertions check four things: a transmitter mismatch on a data bit raises the flag, the flag holds until cleared, slave modes and the transmitter's acknowledge slot never raise it, and a stopped clock stays stopped. Clocking continues at the moment of loss and the SDA line is released while the flag is set. Only the bench's scenarios can show the full sequences. These are clocking continuing through the rest of a byte lost at bit 3 and stopping exactly after the ninth clock, receiver loss confined to a not-acknowledge, and identical data from a competing master passing untouched.

// File: rtl/i2c_arb_guard.sv
module i2c_arb_guard #(
  parameter int CNT_W    = 4,
  parameter int LAST_BIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise_stb,
  input  logic             bit_done_stb,
  input  logic [CNT_W-1:0] bit_idx,
  input  logic [1:0]       mode_in,
  input  logic             sda_drive,
  input  logic             sda_in,
  input  logic             clr_lost,
  output logic             arb_lost,
  output logic [1:0]       mode_out,
  output logic             sda_out,
  output logic             scl_en
);
  localparam logic [1:0] MODE_MTX = 2'b00;
  localparam logic [1:0] MODE_MRX = 2'b01;
  localparam logic [1:0] MODE_SRX = 2'b10;
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(LAST_BIT);

  logic stop_q;
  logic mismatch, tx_loss, rx_loss, lose, byte_end;

  assign mismatch = scl_rise_stb && sda_drive && !sda_in;
  assign tx_loss  = (mode_in == MODE_MTX) && (bit_idx < ACK_IDX) && mismatch;
  assign rx_loss  = (mode_in == MODE_MRX) && (bit_idx == ACK_IDX) && mismatch;
  assign lose     = !arb_lost && (tx_loss || rx_loss);
  assign byte_end = bit_done_stb && (bit_idx == ACK_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_lost) begin
      arb_lost <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      if (lose) arb_lost <= 1'b1;
      if ((arb_lost || lose) && byte_end) stop_q <= 1'b1;
    end
  end

  assign mode_out = arb_lost ? MODE_SRX : mode_in;
  assign sda_out  = sda_drive | arb_lost;
  assign scl_en   = !stop_q;

  // R2
  a_r2_tx_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == MODE_MTX && bit_idx < ACK_IDX && scl_rise_stb && sda_drive && !sda_in && !clr_lost)
      |=> arb_lost);
  // R4
  a_r4_ack_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == MODE_MTX && bit_idx == ACK_IDX && !arb_lost && !clr_lost) |=> !arb_lost);
  // R10
  a_r10_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in[1] && !arb_lost && !clr_lost) |=> !arb_lost);
  // R9
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !clr_lost) |=> arb_lost);
  a_r9_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_en && !clr_lost) |=> !scl_en);
  // R8
  a_r8_clock_continues: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> scl_en);
  // R7
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> sda_out);
endmodule

// File: tb/tb_i2c_arb_guard.sv
module tb_i2c_arb_guard;
  logic clk = 0, rst_n = 0;
  logic scl_rise_stb = 0, bit_done_stb = 0, sda_drive = 1, sda_in = 1, clr_lost = 0;
  logic [3:0] bit_idx = 0;
  logic [1:0] mode_in = 2'b00;
  logic arb_lost, sda_out, scl_en;
  logic [1:0] mode_out;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2c_arb_guard dut (.clk, .rst_n, .scl_rise_stb, .bit_done_stb, .bit_idx, .mode_in,
    .sda_drive, .sda_in, .clr_lost, .arb_lost, .mode_out, .sda_out, .scl_en);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // one bit: sample strobe, then end-of-bit strobe; returns on a negedge
  task automatic do_bit(input logic [1:0] m, input int idx, input logic drv, input logic line);
    mode_in = m; bit_idx = 4'(idx); sda_drive = drv; sda_in = line;
    scl_rise_stb = 1; @(negedge clk);
    scl_rise_stb = 0; bit_done_stb = 1; @(negedge clk);
    bit_done_stb = 0; @(negedge clk);
  endtask

  task automatic clear;
    clr_lost = 1; @(negedge clk); clr_lost = 0; @(negedge clk);
  endtask

  task automatic t_reset;
    chk_eq("R1 arb_lost", arb_lost, 0);
    chk_eq("R1 scl_en", scl_en, 1);
    mode_in = 2'b01; sda_drive = 0; #0;
    chk_eq("R1 mode_out", mode_out, 1);
    chk_eq("R1 sda_out", sda_out, 0);
    mode_in = 2'b00; sda_drive = 1;
  endtask

  task automatic t_identical;
    logic [7:0] b = 8'hA5;
    for (int i = 0; i < 8; i++) do_bit(2'b00, i, b[7-i], b[7-i]);
    chk_eq("R3 identical data", arb_lost, 0);
    do_bit(2'b00, 8, 1'b1, 1'b0);
    chk_eq("R4 ack slot low", arb_lost, 0);
    chk_eq("R4 scl_en", scl_en, 1);
  endtask

  task automatic t_no_strobe;
    mode_in = 2'b00; bit_idx = 2; sda_drive = 1; sda_in = 0;
    repeat (4) @(negedge clk);
    chk_eq("R3 mismatch without strobe", arb_lost, 0);
    do_bit(2'b00, 2, 1'b0, 1'b0);
    chk_eq("R3 driving low", arb_lost, 0);
  endtask

  task automatic t_tx_loss;
    do_bit(2'b00, 0, 1'b0, 1'b0);
    do_bit(2'b00, 1, 1'b1, 1'b1);
    do_bit(2'b00, 2, 1'b0, 1'b0);
    mode_in = 2'b00; bit_idx = 3; sda_drive = 1; sda_in = 0;
    scl_rise_stb = 1; @(negedge clk); scl_rise_stb = 0;
    chk_eq("R2 lost after mismatch", arb_lost, 1);
    chk_eq("R6 mode slave rx", mode_out, 2);
    sda_drive = 0; #0;
    chk_eq("R7 sda released", sda_out, 1);
    chk_eq("R8 clock continues", scl_en, 1);
    bit_done_stb = 1; @(negedge clk); bit_done_stb = 0; @(negedge clk);
    for (int i = 4; i < 8; i++) do_bit(2'b00, i, 1'b0, 1'b1);
    chk_eq("R8 clock through byte", scl_en, 1);
    mode_in = 2'b00; bit_idx = 8; scl_rise_stb = 1; @(negedge clk); scl_rise_stb = 0;
    chk_eq("R8 ninth clock high", scl_en, 1);
    bit_done_stb = 1; @(negedge clk); bit_done_stb = 0;
    chk_eq("R8 stopped after byte", scl_en, 0);
    repeat (5) @(negedge clk);
    chk_eq("R9 flag sticky", arb_lost, 1);
    chk_eq("R9 stop sticky", scl_en, 0);
    clear;
    chk_eq("R9 flag cleared", arb_lost, 0);
    chk_eq("R9 clock restored", scl_en, 1);
    mode_in = 2'b11; #0;
    chk_eq("R6 passthrough", mode_out, 3);
  endtask

  task automatic t_rx;
    for (int i = 0; i < 8; i++) do_bit(2'b01, i, 1'b1, i[0]);
    chk_eq("R5 data bits no loss", arb_lost, 0);
    do_bit(2'b01, 8, 1'b0, 1'b0);
    chk_eq("R5 ack no loss", arb_lost, 0);
    mode_in = 2'b01; bit_idx = 8; sda_drive = 1; sda_in = 0;
    scl_rise_stb = 1; @(negedge clk); scl_rise_stb = 0;
    chk_eq("R5 nack overruled", arb_lost, 1);
    chk_eq("R8 rx clock still on", scl_en, 1);
    bit_done_stb = 1; @(negedge clk); bit_done_stb = 0;
    chk_eq("R8 rx clock stops", scl_en, 0);
    chk_eq("R6 rx mode", mode_out, 2);
    clear;
  endtask

  task automatic t_slave;
    for (int i = 0; i < 9; i++) do_bit(2'b10, i, 1'b1, 1'b0);
    chk_eq("R10 slave rx", arb_lost, 0);
    for (int i = 0; i < 9; i++) do_bit(2'b11, i, 1'b1, 1'b0);
    chk_eq("R10 slave tx", arb_lost, 0);
    chk_eq("R10 scl_en", scl_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset;
    t_identical;
    t_no_strobe;
    t_tx_loss;
    t_rx;
    t_slave;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule